// File: doc/BRIEF.md
# Fractional-Increment Precision Time Counter

This block keeps the local precision time for a port that runs on a 625 MHz clock, where one clock step is 1600 ps. Its core is a 96-bit fixed-point accumulator. The top 64 bits count nanoseconds and the low 32 bits hold fractions of a nanosecond. On every clock edge the accumulator grows by a programmable 64-bit step, which is a 32.32 fixed-point value. So a step of 1.6 ns, or one trimmed by parts per billion, can be represented directly. The time presented to the capture logic is the integer part of the accumulator plus a 64-bit software offset.

Software controls the counter through a small 32-bit register port. It can:
- set the absolute time, which is folded into the offset rather than reloading the accumulator;
- change the step;
- load a signed slew, which moves the time by one nanosecond per cycle until it is used up.

All 64-bit quantities are reached as low/high halves. A read of the low half captures the high half of the same sample. A write of the high half commits the whole value together with the low half staged earlier. After reset the step is zero, so the time stays still until software programs it.

Top module: `phc_clock`

Register selector values on `reg_addr`:

| Value | Register |
|-------|----------|
| 0 | Time, low half |
| 1 | Time, high half |
| 2 | Step, low half |
| 3 | Step, high half |
| 4 | Slew |
| 5 to 7 | Not mapped |

## Requirements
- R1: After reset `time_ns` is 0, `rd_data` is 0, and the step is 0. While the step and the pending slew are both zero and no register is written, `time_ns` does not change.
- R2: On each clock edge the 96-bit accumulator adds the 64-bit step. The step is in 32.32 format: bits 63:32 are nanoseconds and bits 31:0 are the fraction. `time_ns` equals accumulator bits 95:32 plus the offset.
- R3: A write to selector 2 (step, low half) only stages the value. A write to selector 3 (step, high half) commits the step {high, staged low}. The accumulator uses the old step on that edge and the new step from the next edge on.
- R4: A write to selector 0 (time, low half) only stages the value and leaves `time_ns` unchanged. A write to selector 1 (time, high half) makes the time equal {high, staged low} plus whatever the accumulator advances on that same edge. With a zero step and no slew, `time_ns` equals the written value exactly in the next cycle.
- R5: While the slew magnitude is nonzero, each edge adds 2^32 to the accumulator, or subtracts 2^32 when the sign is set, and decrements the magnitude by one. At zero, the slew stops.
- R6: A write to selector 4 loads the slew. Data bit 31 is the sign (1 means negative) and bits 30:0 are the magnitude. Reading selector 4 returns the remaining magnitude in bits 30:0 and the sign in bit 31.
- R7: A slew write replaces any slew still pending; the two are not added.
- R8: Reading selector 0 returns time bits 31:0 and captures time bits 63:32 of the same sample. Reading selector 1 returns the captured value, however far the time has moved since.
- R9: Reading selector 2 returns step bits 31:0 and captures step bits 63:32. Reading selector 3 returns that captured value, even if the step has been committed again since.
- R10: The accumulator wraps modulo 2^96, and the time sum wraps modulo 2^64.
- R11: Read data appears on `rd_data` in the cycle after `rd_en`. In any other cycle `rd_data` is 0, and a read of an unmapped selector (5 to 7) returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 625 MHz time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register selector |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| time_ns | output | 64 | Current time in nanoseconds |

## Verification
The properties assume that the strobes and the selector are known values after reset, and that software does not expect a read to return a value written in the same cycle. The hold properties are conditioned on the absence of a write to the register they watch. The random stimulus therefore leaves idle cycles between accesses, so that those conditions are frequently met. Slew magnitudes in random traffic are limited to eight bits, so that whole drains, and replacements made in the middle of a drain, both occur within the run.

// File: rtl/phc_pkg.sv
package phc_pkg;
    localparam int BUS_W     = 32;
    localparam int NS_W      = 2 * BUS_W;
    localparam int FRAC_W    = 32;
    localparam int ACC_W     = NS_W + FRAC_W;
    localparam int INC_W     = 2 * BUS_W;
    localparam int SLEW_W    = BUS_W - 1;
    localparam int ADDR_W    = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_TIME_LO = 3'd0,
        SEL_TIME_HI = 3'd1,
        SEL_STEP_LO = 3'd2,
        SEL_STEP_HI = 3'd3,
        SEL_SLEW    = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [INC_W-1:0]  step;
        logic [SLEW_W-1:0] slew_mag;
        logic              slew_neg;
    } accum_state_t;

    typedef struct packed {
        logic [BUS_W-1:0] time_lo_stage;
        logic [BUS_W-1:0] step_lo_stage;
        logic [BUS_W-1:0] time_hi_hold;
        logic [BUS_W-1:0] step_hi_hold;
        logic [NS_W-1:0]  offset;
        logic [BUS_W-1:0] rdata;
    } regs_state_t;
endpackage

// File: rtl/phc_accum.sv
module phc_accum
    import phc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_load,
    input  logic [INC_W-1:0]  step_val,
    input  logic              slew_load,
    input  logic [SLEW_W-1:0] slew_mag_in,
    input  logic              slew_neg_in,
    output logic [NS_W-1:0]   acc_ns,
    output logic [INC_W-1:0]  step_o,
    output logic [SLEW_W-1:0] slew_mag_o,
    output logic              slew_neg_o
);
    localparam logic [ACC_W-1:0] ONE_NS = ACC_W'(1) << FRAC_W;

    accum_state_t s_d, s_q;
    logic [ACC_W-1:0] base_sum;

    always_comb begin
        s_d      = s_q;
        base_sum = s_q.acc + ACC_W'(s_q.step);
        if (s_q.slew_mag != '0) begin
            s_d.acc      = s_q.slew_neg ? (base_sum - ONE_NS) : (base_sum + ONE_NS);
            s_d.slew_mag = s_q.slew_mag - SLEW_W'(1);
        end else begin
            s_d.acc      = base_sum;
        end
        if (step_load) begin
            s_d.step = step_val;
        end
        if (slew_load) begin
            s_d.slew_mag = slew_mag_in;
            s_d.slew_neg = slew_neg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign acc_ns     = s_q.acc[ACC_W-1:FRAC_W];
    assign step_o     = s_q.step;
    assign slew_mag_o = s_q.slew_mag;
    assign slew_neg_o = s_q.slew_neg;

    // R5: a pending slew drains by exactly one per cycle
    p_slew_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slew_mag_o != '0 && !slew_load) |=> slew_mag_o == $past(slew_mag_o) - SLEW_W'(1));

    // R5: an idle slew stays idle
    p_slew_rest_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slew_mag_o == '0 && !slew_load) |=> slew_mag_o == '0);

    // R3: the step only changes on a commit
    p_step_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_load |=> $stable(step_o));

    // R7: a new slew replaces the pending one
    p_slew_replace_r7: assert property (@(posedge clk) disable iff (!rst_n)
        slew_load |=> (slew_mag_o == $past(slew_mag_in) && slew_neg_o == $past(slew_neg_in)));
endmodule

// File: rtl/phc_regs.sv
module phc_regs
    import phc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic [NS_W-1:0]   acc_ns,
    input  logic [INC_W-1:0]  step_cur,
    input  logic [SLEW_W-1:0] slew_mag_cur,
    input  logic              slew_neg_cur,
    output logic              step_load,
    output logic [INC_W-1:0]  step_val,
    output logic              slew_load,
    output logic [SLEW_W-1:0] slew_mag_in,
    output logic              slew_neg_in,
    output logic [NS_W-1:0]   time_ns,
    output logic [BUS_W-1:0]  rd_data
);
    regs_state_t s_d, s_q;
    logic [NS_W-1:0] new_time;

    assign time_ns = acc_ns + s_q.offset;

    always_comb begin
        s_d         = s_q;
        s_d.rdata   = '0;
        step_load   = 1'b0;
        slew_load   = 1'b0;
        step_val    = {wr_data, s_q.step_lo_stage};
        slew_mag_in = wr_data[SLEW_W-1:0];
        slew_neg_in = wr_data[BUS_W-1];
        new_time    = {wr_data, s_q.time_lo_stage};

        if (rd_en) begin
            case (reg_addr)
                SEL_TIME_LO: begin
                    s_d.rdata        = time_ns[BUS_W-1:0];
                    s_d.time_hi_hold = time_ns[NS_W-1:BUS_W];
                end
                SEL_TIME_HI: s_d.rdata = s_q.time_hi_hold;
                SEL_STEP_LO: begin
                    s_d.rdata        = step_cur[BUS_W-1:0];
                    s_d.step_hi_hold = step_cur[INC_W-1:BUS_W];
                end
                SEL_STEP_HI: s_d.rdata = s_q.step_hi_hold;
                SEL_SLEW:    s_d.rdata = {slew_neg_cur, slew_mag_cur};
                default:     s_d.rdata = '0;
            endcase
        end

        if (wr_en) begin
            case (reg_addr)
                SEL_TIME_LO: s_d.time_lo_stage = wr_data;
                SEL_TIME_HI: s_d.offset        = s_q.offset + (new_time - time_ns);
                SEL_STEP_LO: s_d.step_lo_stage = wr_data;
                SEL_STEP_HI: step_load         = 1'b1;
                SEL_SLEW:    slew_load         = 1'b1;
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.rdata;

    // R8: the captured high half moves only on a low-half time read
    p_time_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && reg_addr == SEL_TIME_LO) |=> $stable(s_q.time_hi_hold));

    // R9: same for the step pair
    p_step_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && reg_addr == SEL_STEP_LO) |=> $stable(s_q.step_hi_hold));

    // R11: no read, no data
    p_rdata_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rd_data == '0);

    // R4: the offset only moves on a high-half time write
    p_offset_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_addr == SEL_TIME_HI) |=> $stable(s_q.offset));
endmodule

// File: rtl/phc_clock.sv
module phc_clock
    import phc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  wr_data,
    output logic [BUS_W-1:0]  rd_data,
    output logic [NS_W-1:0]   time_ns
);
    logic              step_load;
    logic [INC_W-1:0]  step_val;
    logic              slew_load;
    logic [SLEW_W-1:0] slew_mag_in;
    logic              slew_neg_in;
    logic [NS_W-1:0]   acc_ns;
    logic [INC_W-1:0]  step_cur;
    logic [SLEW_W-1:0] slew_mag_cur;
    logic              slew_neg_cur;

    phc_accum i_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_load   (step_load),
        .step_val    (step_val),
        .slew_load   (slew_load),
        .slew_mag_in (slew_mag_in),
        .slew_neg_in (slew_neg_in),
        .acc_ns      (acc_ns),
        .step_o      (step_cur),
        .slew_mag_o  (slew_mag_cur),
        .slew_neg_o  (slew_neg_cur)
    );

    phc_regs i_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .reg_addr     (reg_addr),
        .wr_data      (wr_data),
        .acc_ns       (acc_ns),
        .step_cur     (step_cur),
        .slew_mag_cur (slew_mag_cur),
        .slew_neg_cur (slew_neg_cur),
        .step_load    (step_load),
        .step_val     (step_val),
        .slew_load    (slew_load),
        .slew_mag_in  (slew_mag_in),
        .slew_neg_in  (slew_neg_in),
        .time_ns      (time_ns),
        .rd_data      (rd_data)
    );

    // R1: with zero step, no slew and no write, time stands still
    p_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_cur == '0 && slew_mag_cur == '0 && !wr_en) |=> $stable(time_ns));
endmodule

// File: tb/test_phc_clock.sv
`timescale 1ns/1ps
module test_phc_clock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [63:0] time_ns;

    int n_checks = 0;
    int n_fail   = 0;

    // reference state, built from the requirements
    logic [95:0] m_acc;
    logic [63:0] m_step, m_off;
    logic [30:0] m_mag;
    logic        m_neg;
    logic [31:0] m_tlo, m_slo, m_thold, m_shold, m_rd;

    phc_clock i_phc_clock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data), .time_ns(time_ns)
    );

    always #2.5 clk = ~clk;

    function automatic logic [63:0] m_time();
        return m_acc[95:32] + m_off;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_edge(input bit we, input bit re, input logic [2:0] a, input logic [31:0] d);
        logic [63:0] t;
        logic [95:0] nacc;
        logic [30:0] nmag;
        t = m_time();
        m_rd = '0;
        if (re) begin
            case (a)
                3'd0: begin m_rd = t[31:0]; m_thold = t[63:32]; end
                3'd1: m_rd = m_thold;
                3'd2: begin m_rd = m_step[31:0]; m_shold = m_step[63:32]; end
                3'd3: m_rd = m_shold;
                3'd4: m_rd = {m_neg, m_mag};
                default: m_rd = '0;
            endcase
        end
        nacc = m_acc + {32'd0, m_step};
        nmag = m_mag;
        if (m_mag != 0) begin
            nacc = m_neg ? nacc - (96'd1 << 32) : nacc + (96'd1 << 32);
            nmag = m_mag - 31'd1;
        end
        if (we) begin
            case (a)
                3'd0: m_tlo = d;
                3'd1: m_off = m_off + ({d, m_tlo} - t);
                3'd2: m_slo = d;
                3'd3: m_step = {d, m_slo};
                3'd4: begin nmag = d[30:0]; m_neg = d[31]; end
                default: ;
            endcase
        end
        m_acc = nacc;
        m_mag = nmag;
    endtask

    task automatic cyc(input bit we, input bit re, input logic [2:0] a, input logic [31:0] d);
        wr_en = we; rd_en = re; reg_addr = a; wr_data = d;
        @(posedge clk);
        model_edge(we, re, a, d);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check(time_ns == m_time(), "R2 time", time_ns, m_time());
        check(rd_data == m_rd, "R11 rdata", {32'd0, rd_data}, {32'd0, m_rd});
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 3'd0, 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] t0;
        logic [31:0] d;
        logic [2:0]  a;
        m_acc = '0; m_step = '0; m_off = '0; m_mag = '0; m_neg = 1'b0;
        m_tlo = '0; m_slo = '0; m_thold = '0; m_shold = '0; m_rd = '0;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(time_ns == 64'd0, "R1 reset time", time_ns, 64'd0);
        check(rd_data == 32'd0, "R1 reset rdata", {32'd0, rd_data}, 64'd0);
        idle(5);
        check(time_ns == 64'd0, "R1 frozen", time_ns, 64'd0);

        // R4 time set with zero step
        cyc(1, 0, 3'd0, 32'h0000_1000);
        check(time_ns == 64'd0, "R4 low only stages", time_ns, 64'd0);
        cyc(1, 0, 3'd1, 32'h0000_0007);
        check(time_ns == 64'h7_0000_1000, "R4 set exact", time_ns, 64'h7_0000_1000);
        idle(3);
        check(time_ns == 64'h7_0000_1000, "R1 no advance", time_ns, 64'h7_0000_1000);

        // R3 step 1.5 ns
        cyc(1, 0, 3'd2, 32'h8000_0000);
        check(time_ns == 64'h7_0000_1000, "R3 low only stages", time_ns, 64'h7_0000_1000);
        cyc(1, 0, 3'd3, 32'h0000_0001);
        check(time_ns == 64'h7_0000_1000, "R3 old step on commit edge", time_ns, 64'h7_0000_1000);
        idle(4);
        check(time_ns == 64'h7_0000_1006, "R2 fractional step", time_ns, 64'h7_0000_1006);

        // R9 step pair capture
        cyc(0, 1, 3'd2, 32'd0);
        check(rd_data == 32'h8000_0000, "R9 step low", {32'd0, rd_data}, 64'h8000_0000);
        cyc(1, 0, 3'd3, 32'h0000_0002);
        cyc(0, 1, 3'd3, 32'd0);
        check(rd_data == 32'd1, "R9 held high", {32'd0, rd_data}, 64'd1);

        // R8 time pair capture across a high-half carry
        cyc(1, 0, 3'd0, 32'hFFFF_FFF8);
        cyc(1, 0, 3'd1, 32'h0000_0002);
        cyc(0, 1, 3'd0, 32'd0);
        idle(5);
        check(time_ns[63:32] == 32'd3, "R8 carry happened", time_ns, 64'h3_0000_0000);
        cyc(0, 1, 3'd1, 32'd0);
        check(rd_data == 32'd2, "R8 held high", {32'd0, rd_data}, 64'd2);

        // R5/R6 positive slew with zero step
        cyc(1, 0, 3'd2, 32'd0);
        cyc(1, 0, 3'd3, 32'd0);
        t0 = time_ns;
        cyc(1, 0, 3'd4, 32'd5);
        cyc(0, 1, 3'd4, 32'd0);
        check(rd_data == 32'd5, "R6 slew readback", {32'd0, rd_data}, 64'd5);
        idle(6);
        check(time_ns == t0 + 64'd5, "R5 slew drained", time_ns, t0 + 64'd5);
        cyc(0, 1, 3'd4, 32'd0);
        check(rd_data == 32'd0, "R6 slew empty", {32'd0, rd_data}, 64'd0);

        // R7 replace a negative slew mid-drain
        t0 = time_ns;
        cyc(1, 0, 3'd4, 32'h8000_0064);
        idle(2);
        cyc(1, 0, 3'd4, 32'd3);
        cyc(0, 1, 3'd4, 32'd0);
        check(rd_data == 32'd3, "R7 replaced", {32'd0, rd_data}, 64'd3);
        idle(5);
        check(time_ns == t0, "R7 net zero", time_ns, t0);

        // R10 wrap
        cyc(1, 0, 3'd0, 32'hFFFF_FFF0);
        cyc(1, 0, 3'd1, 32'hFFFF_FFFF);
        check(time_ns == 64'hFFFF_FFFF_FFFF_FFF0, "R10 near top", time_ns, 64'hFFFF_FFFF_FFFF_FFF0);
        cyc(1, 0, 3'd2, 32'd0);
        cyc(1, 0, 3'd3, 32'd1);
        idle(20);
        check(time_ns == 64'd4, "R10 wrapped", time_ns, 64'd4);

        // R11 unmapped
        cyc(0, 1, 3'd7, 32'd0);
        check(rd_data == 32'd0, "R11 unmapped 7", {32'd0, rd_data}, 64'd0);
        cyc(0, 1, 3'd5, 32'd0);
        check(rd_data == 32'd0, "R11 unmapped 5", {32'd0, rd_data}, 64'd0);

        // random traffic against the reference
        for (int i = 0; i < 800; i++) begin
            int op;
            op = $urandom_range(0, 9);
            a  = 3'($urandom_range(0, 7));
            d  = $urandom();
            if (a == 3'd4) d = {d[31], 23'd0, d[7:0]};
            if (op < 3)      cyc(1, 0, a, d);
            else if (op < 6) cyc(0, 1, a, d);
            else if (op < 7) cyc(1, 1, a, d);
            else             idle(1);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule